// File: doc/BRIEF.md
# Privileged Control Register Unit

This unit holds three privileged control registers of a 32-bit big-endian RISC core: a state word, a register-window validity mask and a trap table base. It runs decoded read and write special-register operations. Every write stores the exclusive-OR of the first source operand with either the second source operand or a sign-extended 13-bit immediate. A read returns the selected register on the destination data port in the same cycle. The state word's fields go out on separate pins so the rest of the core can use them directly.

The operation side uses a valid/ready handshake. `op_ready` is always high, so the unit never applies back-pressure. An operation is consumed in any cycle where `op_valid` is high. A write takes effect at the next rising clock edge. Fault flags and read data are combinational results of the operation on the inputs in that cycle. Trap logic loads the trap-type field of the base register through its own plain strobe. Nothing else can write that field.

Top module: `ctrl_state_regs`

## Requirements
- R1: After reset the supervisor bit is 1. Interrupt level, window pointer, trap-enable, previous-supervisor, coprocessor-enable and FPU-enable are all 0. The mask register and the trap base read as 0.
- R2: A write with `op_imm_sel`=0 and `op_asi`=0 stores `op_rs1 ^ op_rs2` into the register picked by `op_sel` (0 state word, 1 window mask, 2 trap base). `op_kind` encodes 1 = read and 2 = write.
- R3: A write with `op_imm_sel`=1 stores `op_rs1` XOR `op_imm13` sign-extended to 32 bits. In this form `op_asi` is not checked.
- R4: A register-form write with `op_asi` non-zero raises `illegal_fault` and updates no register.
- R5: The state word layout is: window pointer in 4:0, trap-enable in 5, previous-supervisor in 6, supervisor in 7, interrupt level in 11:8, FPU-enable in 12, coprocessor-enable in 13. Bits 23:14 read 0. Bits 31:24 read the constant `IMPL_VER` (default 8'h3C). Writes to bits 31:14 have no effect.
- R6: A state-word write whose window pointer is NWINDOWS (default 8) or larger raises `illegal_fault` and leaves the whole state word unchanged.
- R7: A trap base write replaces only bits 31:12. Bits 11:4 keep their contents, and bits 3:0 always read 0.
- R8: A cycle with `tt_load`=1 loads `tt_value` into trap base bits 11:4 at the next edge.
- R9: The window mask reads as the stored value ANDed with (1<<NWINDOWS)-1.
- R10: While the supervisor bit is 0, any valid read or write raises `priv_fault` (and not `illegal_fault`), updates no register, and drives `rd_data` to 0.
- R11: A write becomes visible at the clock edge after it is presented. During the write cycle the field outputs still show the old value.
- R12: With `op_valid`=0, or with `op_kind` 0 or 3, no fault is raised, no register changes and `rd_data` is 0. `op_ready` is always 1.
- R13: `op_sel`=3 raises `illegal_fault` for reads and writes, updates nothing, and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Always 1; no back-pressure |
| op_kind | input | 2 | 1 read, 2 write, others no-op |
| op_sel | input | 2 | 0 state word, 1 window mask, 2 trap base, 3 reserved |
| op_imm_sel | input | 1 | 1 selects immediate form |
| op_rs1 | input | 32 | First source operand |
| op_rs2 | input | 32 | Second source operand |
| op_imm13 | input | 13 | Immediate, sign-extended internally |
| op_asi | input | 8 | Reserved field; must be 0 in register form |
| rd_data | output | 32 | Read result for the destination register |
| priv_fault | output | 1 | Privileged operation attempted in user mode |
| illegal_fault | output | 1 | Malformed or out-of-range operation |
| tt_load | input | 1 | Trap logic strobe for trap-type field |
| tt_value | input | 8 | Trap type for base bits 11:4 |
| st_super | output | 1 | Supervisor bit |
| st_prev_super | output | 1 | Previous supervisor bit |
| st_pil | output | 4 | Interrupt level |
| st_en_traps | output | 1 | Trap enable |
| st_cp_en | output | 1 | Coprocessor enable |
| st_fp_en | output | 1 | FPU enable |
| st_cwp | output | 5 | Current window pointer |

## Verification
The privilege fault is the hardest case to reach from the ports. The supervisor bit comes out of reset set, and only a write through the unit itself can clear it. Once cleared, only reset restores it. The stimulus therefore runs the user-mode scenario last. It first drops the supervisor bit with a legal state-word write of 0, then checks that reads, writes and an out-of-range window pointer are all refused as privileged and change nothing. The window-pointer boundary is driven at exactly NWINDOWS and NWINDOWS-1.

// File: rtl/ctrl_state_pkg.sv
package ctrl_state_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_RSVD  = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    SEL_STATE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_TBASE = 2'd2,
    SEL_RSVD  = 2'd3
  } op_sel_e;

  // Low 14 bits of the state word, MSB first.
  typedef struct packed {
    logic       ec;
    logic       ef;
    logic [3:0] pil;
    logic       s;
    logic       ps;
    logic       et;
    logic [4:0] cwp;
  } state_fields_t;

  localparam int STATE_FIELD_W = 14;
endpackage

// File: rtl/csr_op_decode.sv
module csr_op_decode
  import ctrl_state_pkg::*;
#(
  parameter int NWINDOWS = 8,
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 13,
  parameter int ASI_W    = 8
) (
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [1:0]        op_sel,
  input  logic              op_imm_sel,
  input  logic [DATA_W-1:0] op_rs1,
  input  logic [DATA_W-1:0] op_rs2,
  input  logic [IMM_W-1:0]  op_imm13,
  input  logic [ASI_W-1:0]  op_asi,
  input  logic              super_mode,
  output logic [DATA_W-1:0] wr_val,
  output logic              wr_state,
  output logic              wr_mask,
  output logic              wr_tbase,
  output logic              rd_en,
  output logic              priv_fault,
  output logic              illegal_fault
);
  logic [DATA_W-1:0] operand_b;
  logic active, is_rd, is_wr, asi_bad, sel_bad, cwp_bad, ok;

  assign operand_b = op_imm_sel ? {{(DATA_W-IMM_W){op_imm13[IMM_W-1]}}, op_imm13} : op_rs2;
  assign wr_val    = op_rs1 ^ operand_b;

  assign is_rd  = (op_kind == KIND_READ);
  assign is_wr  = (op_kind == KIND_WRITE);
  assign active = op_valid && (is_rd || is_wr);

  generate
    if (NWINDOWS < 32) begin : g_cwp_chk
      localparam logic [4:0] NW5 = 5'(NWINDOWS);
      assign cwp_bad = is_wr && (op_sel == SEL_STATE) && (wr_val[4:0] >= NW5);
    end else begin : g_cwp_all
      assign cwp_bad = 1'b0;
    end
  endgenerate

  assign asi_bad = is_wr && !op_imm_sel && (op_asi != '0);
  assign sel_bad = (op_sel == SEL_RSVD);

  assign priv_fault    = active && !super_mode;
  assign illegal_fault = active && super_mode && (sel_bad || asi_bad || cwp_bad);
  assign ok            = active && super_mode && !(sel_bad || asi_bad || cwp_bad);

  assign wr_state = ok && is_wr && (op_sel == SEL_STATE);
  assign wr_mask  = ok && is_wr && (op_sel == SEL_MASK);
  assign wr_tbase = ok && is_wr && (op_sel == SEL_TBASE);
  assign rd_en    = ok && is_rd;
endmodule

// File: rtl/state_word_reg.sv
module state_word_reg
  import ctrl_state_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [STATE_FIELD_W-1:0] wr_bits,
  output state_fields_t            state_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= '0;
      state_q.s   <= 1'b1;
    end else if (wr_en) begin
      state_q <= state_fields_t'(wr_bits);
    end
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(state_q));
endmodule

// File: rtl/trap_base_reg.sv
module trap_base_reg #(
  parameter int HI_W = 20,
  parameter int TT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [HI_W-1:0] wr_hi,
  input  logic            tt_load,
  input  logic [TT_W-1:0] tt_value,
  output logic [HI_W-1:0] hi_q,
  output logic [TT_W-1:0] tt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      tt_q <= '0;
    end else begin
      if (wr_en)   hi_q <= wr_hi;
      if (tt_load) tt_q <= tt_value;
    end
  end

  // R7
  tt_kept_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !tt_load) |=> $stable(tt_q));

  // R8
  tt_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tt_load |=> (tt_q == $past(tt_value)));
endmodule

// File: rtl/ctrl_state_regs.sv
module ctrl_state_regs
  import ctrl_state_pkg::*;
#(
  parameter int         NWINDOWS = 8,
  parameter logic [7:0] IMPL_VER = 8'h3C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  output logic        op_ready,
  input  logic [1:0]  op_kind,
  input  logic [1:0]  op_sel,
  input  logic        op_imm_sel,
  input  logic [31:0] op_rs1,
  input  logic [31:0] op_rs2,
  input  logic [12:0] op_imm13,
  input  logic [7:0]  op_asi,
  output logic [31:0] rd_data,
  output logic        priv_fault,
  output logic        illegal_fault,
  input  logic        tt_load,
  input  logic [7:0]  tt_value,
  output logic        st_super,
  output logic        st_prev_super,
  output logic [3:0]  st_pil,
  output logic        st_en_traps,
  output logic        st_cp_en,
  output logic        st_fp_en,
  output logic [4:0]  st_cwp
);
  localparam int          DATA_W   = 32;
  localparam int          TT_W     = 8;
  localparam int          TT_LSB   = 4;
  localparam int          HI_W     = DATA_W - TT_W - TT_LSB;
  localparam int          PAD_W    = DATA_W - 8 - STATE_FIELD_W;
  localparam logic [32:0] MASK33   = (33'd1 << NWINDOWS) - 33'd1;
  localparam logic [31:0] WIN_MASK = MASK33[31:0];

  logic [DATA_W-1:0] wr_val;
  logic wr_state, wr_mask, wr_tbase, rd_en;
  state_fields_t     state_q;
  logic [DATA_W-1:0] mask_q;
  logic [HI_W-1:0]   tb_hi_q;
  logic [TT_W-1:0]   tb_tt_q;

  assign op_ready = 1'b1;

  csr_op_decode #(.NWINDOWS(NWINDOWS), .DATA_W(DATA_W), .IMM_W(13), .ASI_W(8)) u_dec (
    .op_valid(op_valid), .op_kind(op_kind), .op_sel(op_sel), .op_imm_sel(op_imm_sel),
    .op_rs1(op_rs1), .op_rs2(op_rs2), .op_imm13(op_imm13), .op_asi(op_asi),
    .super_mode(state_q.s), .wr_val(wr_val), .wr_state(wr_state), .wr_mask(wr_mask),
    .wr_tbase(wr_tbase), .rd_en(rd_en), .priv_fault(priv_fault), .illegal_fault(illegal_fault)
  );

  state_word_reg u_state (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_state),
    .wr_bits(wr_val[STATE_FIELD_W-1:0]), .state_q(state_q)
  );

  trap_base_reg #(.HI_W(HI_W), .TT_W(TT_W)) u_tbase (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_tbase), .wr_hi(wr_val[DATA_W-1:DATA_W-HI_W]),
    .tt_load(tt_load), .tt_value(tt_value), .hi_q(tb_hi_q), .tt_q(tb_tt_q)
  );

  // Unimplemented window bits are dropped on the way in; they never store.
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wr_val & WIN_MASK;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (op_sel)
        SEL_STATE: rd_data = {IMPL_VER, {PAD_W{1'b0}}, state_q};
        SEL_MASK:  rd_data = mask_q & WIN_MASK;
        SEL_TBASE: rd_data = {tb_hi_q, tb_tt_q, {TT_LSB{1'b0}}};
        default:   rd_data = '0;
      endcase
    end
  end

  assign st_super      = state_q.s;
  assign st_prev_super = state_q.ps;
  assign st_pil        = state_q.pil;
  assign st_en_traps   = state_q.et;
  assign st_cp_en      = state_q.ec;
  assign st_fp_en      = state_q.ef;
  assign st_cwp        = state_q.cwp;

  // R10
  priv_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |=> ($stable(state_q) && $stable(mask_q) && $stable(tb_hi_q)));

  // R4
  illegal_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_fault |=> ($stable(state_q) && $stable(mask_q) && $stable(tb_hi_q)));

  // R10
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(priv_fault && illegal_fault));

  // R11
  write_lands_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_state |=> (st_pil == $past(wr_val[11:8]) && st_cwp == $past(wr_val[4:0])));

  // R7
  tbase_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == SEL_TBASE) |-> (rd_data[3:0] == 4'd0));

  // R9
  mask_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~WIN_MASK) == 32'd0 || op_sel != SEL_MASK);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!priv_fault && !illegal_fault && rd_data == 32'd0));
endmodule

// File: tb/ctrl_state_regs_bench.sv
`timescale 1ns/1ps
module ctrl_state_regs_bench;
  localparam logic [7:0] IMPL = 8'h3C;
  localparam logic [1:0] RD = 2'd1, WR = 2'd2;
  localparam logic [1:0] S_ST = 2'd0, S_MK = 2'd1, S_TB = 2'd2, S_RS = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_imm_sel = 0, tt_load = 0;
  logic [1:0] op_kind = 0, op_sel = 0;
  logic [31:0] op_rs1 = 0, op_rs2 = 0;
  logic [12:0] op_imm13 = 0;
  logic [7:0] op_asi = 0, tt_value = 0;
  logic op_ready, priv_fault, illegal_fault;
  logic [31:0] rd_data;
  logic st_super, st_prev_super, st_en_traps, st_cp_en, st_fp_en;
  logic [3:0] st_pil;
  logic [4:0] st_cwp;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctrl_state_regs u_ctrl_state_regs (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind),
    .op_sel(op_sel), .op_imm_sel(op_imm_sel), .op_rs1(op_rs1), .op_rs2(op_rs2),
    .op_imm13(op_imm13), .op_asi(op_asi), .rd_data(rd_data), .priv_fault(priv_fault),
    .illegal_fault(illegal_fault), .tt_load(tt_load), .tt_value(tt_value),
    .st_super(st_super), .st_prev_super(st_prev_super), .st_pil(st_pil),
    .st_en_traps(st_en_traps), .st_cp_en(st_cp_en), .st_fp_en(st_fp_en), .st_cwp(st_cwp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Present an operation; returns after #1 so combinational outputs can be sampled.
  task automatic issue(input logic [1:0] kind, input logic [1:0] sel, input logic imm,
                       input logic [31:0] a, input logic [31:0] b, input logic [12:0] i13,
                       input logic [7:0] asi);
    @(negedge clk);
    op_valid = 1; op_kind = kind; op_sel = sel; op_imm_sel = imm;
    op_rs1 = a; op_rs2 = b; op_imm13 = i13; op_asi = asi;
    #1;
  endtask

  task automatic retire();
    @(posedge clk);
    #1;
    op_valid = 0; op_kind = 0; op_asi = 0; op_imm_sel = 0;
  endtask

  task automatic read_chk(input logic [1:0] sel, input logic [31:0] exp, input string req);
    issue(RD, sel, 0, 0, 0, 0, 0);
    chk(req, rd_data, exp);
    retire();
  endtask

  task automatic t_reset();
    chk("R1 super", st_super, 1);
    chk("R1 fields", {st_prev_super, st_en_traps, st_cp_en, st_fp_en, st_pil, st_cwp}, 0);
    chk("R12 ready", op_ready, 1);
    read_chk(S_ST, {IMPL, 24'h000080}, "R1/R5 state read");
    read_chk(S_MK, 0, "R1 mask read");
    read_chk(S_TB, 0, "R1 tbase read");
  endtask

  task automatic t_state_write();
    issue(WR, S_ST, 0, 32'h0F0F0000, 32'hF0F01A85, 0, 0);
    chk("R11 old pil during write", st_pil, 0);
    chk("R2 no fault", {priv_fault, illegal_fault}, 0);
    retire();
    chk("R2 pil", st_pil, 4'hA);
    chk("R2 cwp", st_cwp, 5);
    chk("R5 fp/cp", {st_fp_en, st_cp_en}, 2'b10);
    read_chk(S_ST, 32'h3C001A85, "R5 state layout");
  endtask

  task automatic t_mask();
    issue(WR, S_MK, 1, 0, 32'hDEAD_BEEF, 13'h1FFF, 0);
    retire();
    read_chk(S_MK, 32'h0000_00FF, "R3/R9 sign-extended imm clipped");
    issue(WR, S_MK, 0, 32'h5A, 32'h0F, 0, 0);
    retire();
    read_chk(S_MK, 32'h55, "R2 mask reg form");
    issue(WR, S_MK, 1, 32'h0F, 32'hFF, 13'h00A, 0);
    retire();
    read_chk(S_MK, 32'h05, "R3 positive imm");
  endtask

  task automatic t_asi();
    issue(WR, S_MK, 0, 0, 32'hAA, 0, 8'h01);
    chk("R4 illegal flag", illegal_fault, 1);
    retire();
    read_chk(S_MK, 32'h05, "R4 mask unchanged");
    issue(WR, S_MK, 1, 0, 0, 13'h3, 8'hFF);
    chk("R3 imm ignores asi", illegal_fault, 0);
    retire();
    read_chk(S_MK, 32'h03, "R3 imm write with asi");
  endtask

  task automatic t_cwp();
    issue(WR, S_ST, 0, 32'h1A88, 0, 0, 0);
    chk("R6 illegal at NWINDOWS", illegal_fault, 1);
    retire();
    chk("R6 cwp kept", st_cwp, 5);
    chk("R6 pil kept", st_pil, 4'hA);
    issue(WR, S_ST, 0, 32'h0A87, 0, 0, 0);
    chk("R6 NWINDOWS-1 legal", illegal_fault, 0);
    retire();
    chk("R6 cwp 7", st_cwp, 7);
    chk("R5 fp cleared", st_fp_en, 0);
  endtask

  task automatic t_tbase();
    @(negedge clk);
    tt_load = 1; tt_value = 8'hC3;
    @(posedge clk);
    #1 tt_load = 0;
    read_chk(S_TB, 32'h0000_0C30, "R8 trap type load");
    issue(WR, S_TB, 1, 32'h12345000, 0, 13'h0FF, 0);
    retire();
    read_chk(S_TB, 32'h12345C30, "R7 partial write imm");
    issue(WR, S_TB, 0, 32'hFFFFFFFF, 0, 0, 0);
    retire();
    read_chk(S_TB, 32'hFFFFFC30, "R7 low bits zero, tt kept");
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_valid = 0; op_kind = WR; op_sel = S_MK; op_rs1 = 32'hFF; op_rs2 = 0;
    #1;
    chk("R12 idle no fault", {priv_fault, illegal_fault}, 0);
    chk("R12 idle rd zero", rd_data, 0);
    retire();
    issue(2'd3, S_MK, 0, 32'hFF, 0, 0, 0);
    chk("R12 kind3 no fault", {priv_fault, illegal_fault}, 0);
    retire();
    read_chk(S_MK, 32'h03, "R12 mask untouched");
  endtask

  task automatic t_badsel();
    issue(RD, S_RS, 0, 0, 0, 0, 0);
    chk("R13 read illegal", illegal_fault, 1);
    chk("R13 read zero", rd_data, 0);
    retire();
    issue(WR, S_RS, 0, 32'hFFFFFFFF, 0, 0, 0);
    chk("R13 write illegal", illegal_fault, 1);
    retire();
    read_chk(S_MK, 32'h03, "R13 nothing updated");
  endtask

  task automatic t_priv();
    issue(WR, S_ST, 0, 32'h0, 0, 0, 0);
    retire();
    chk("R10 user mode entered", st_super, 0);
    issue(RD, S_ST, 0, 0, 0, 0, 0);
    chk("R10 read priv", {priv_fault, illegal_fault}, 2'b10);
    chk("R10 read zero", rd_data, 0);
    retire();
    issue(WR, S_ST, 0, 32'h80, 0, 0, 0);
    chk("R10 write priv", priv_fault, 1);
    retire();
    chk("R10 super stays 0", st_super, 0);
    issue(WR, S_ST, 0, 32'h9F, 0, 0, 0);
    chk("R10 priv over illegal", {priv_fault, illegal_fault}, 2'b10);
    retire();
    chk("R10 cwp kept", st_cwp, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_reset();
    t_state_write();
    t_mask();
    t_asi();
    t_cwp();
    t_tbase();
    t_idle();
    t_badsel();
    t_priv();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule